// File: doc/BRIEF.md
# Video Timing Measurement Sequencer

This block characterises an incoming video raster so that a host can size and centre the picture automatically. It watches four asynchronous inputs: horizontal sync, vertical sync, horizontal flyback and active video. All counting runs on one fast measurement clock. The host arms a run by writing a control byte with the start bit set. The block then steps through a fixed sequence of phases and clears the start bit by itself when the sequence ends.

The sequence runs in this order. It waits for a vertical sync rising edge. It takes two horizontal minima (sync-to-active delay, then active width), each over N+1 frames. It takes two vertical minima (sync-to-active line count, then active line count), each over N+1 frames. It counts the lines in one frame. After the closing vertical edge of that frame it counts horizontal sync rising edges to a programmed trigger line. On the trigger line it times the low and high portions of horizontal sync and of flyback. Horizontal results are in measurement-clock ticks and vertical results are in lines. All results are 12-bit read-only registers that keep the value of the last run.

Top module: `vtm_seq`

## Requirements
- R1: After reset every result register, the control readback (address 9) and the block register (address 10) read 0, and `busy` is 0.
- R2: The control byte uses bit 7 as start, bits 6:5 as the frame-count field N, and bit 0 as mode (1 = timing). A write while idle stores N and the mode. A run begins only when both start and mode are 1. Address 9 reads {busy, N, 4'b0000, mode}. A start written with mode 0 leaves `busy` at 0 and all results unchanged.
- R3: Writes to the control byte or to the block register while `busy` is 1 have no effect.
- R4: Result H1 (address 0) is the minimum, over every line of N+1 frames, of the ticks from a horizontal sync rising edge to the next active-video rising edge.
- R5: Result H2 (address 1) is the minimum active-video high time in ticks over the following N+1 frames.
- R6: Result V1 (address 6) is the minimum, over the next N+1 frames, of the number of horizontal sync rising edges between the vertical sync rising edge and the first active-video rising edge of the frame.
- R7: Result V2 (address 7) is the minimum count of active-video pulses per frame over the next N+1 frames. With no active video it reads 0.
- R8: Result V3 (address 8) is the number of horizontal sync rising edges in the following single frame, counted up to its closing vertical sync rising edge.
- R9: After that closing edge, the max(4·B, 1)-th horizontal sync rising edge starts the trigger line, where B is the block register (address 10). On that line H4 (address 3) is the sync high time, H3 (address 2) is the sync low time that follows, H6 (address 5) is the first flyback high time and H5 (address 4) is the flyback low time that follows. `busy` then returns to 0.
- R10: Every counter saturates at 0xFFF instead of wrapping.
- R11: Each minimum result is preset to 0xFFF when its phase begins, so a phase with no qualifying event reads 0xFFF.
- R12: Addresses 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_in | input | 1 | Horizontal sync, asynchronous |
| vs_in | input | 1 | Vertical sync, asynchronous |
| fly_in | input | 1 | Horizontal flyback, asynchronous |
| av_in | input | 1 | Active video, asynchronous |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| blk_we | input | 1 | Block register write strobe |
| blk_wdata | input | 8 | Sampling block number B |
| rd_addr | input | 4 | Read address |
| rd_data | output | 12 | Read data (combinational from registers) |
| busy | output | 1 | Start bit as seen by the host; 1 while a run is in progress |

## Verification
A wrong phase or frame count shows up only at the end of a run: the minima land on the wrong frames, the start bit clears one or more frames early or late, or the trigger line moves, so H3 to H6 change. The bench gives each frame its own active-video geometry, so any slip in phase boundaries changes a minimum. A stuck or wrapping counter shows up as a small value where 0xFFF belongs, after the one phase that saturates it. A phase that never presets its minimum shows the previous run's value.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WAIT_VS,
    PH_H1,
    PH_H2,
    PH_V1,
    PH_V2,
    PH_V3,
    PH_WAIT_TRIG,
    PH_CAPT
  } phase_t;

  // Control byte bit positions (host visible)
  localparam int CB_START  = 7;
  localparam int CB_NFR_HI = 6;
  localparam int CB_NFR_LO = 5;
  localparam int CB_MODE   = 0;

  // Read map
  localparam logic [3:0] RA_H1  = 4'd0;
  localparam logic [3:0] RA_H2  = 4'd1;
  localparam logic [3:0] RA_H3  = 4'd2;
  localparam logic [3:0] RA_H4  = 4'd3;
  localparam logic [3:0] RA_H5  = 4'd4;
  localparam logic [3:0] RA_H6  = 4'd5;
  localparam logic [3:0] RA_V1  = 4'd6;
  localparam logic [3:0] RA_V2  = 4'd7;
  localparam logic [3:0] RA_V3  = 4'd8;
  localparam logic [3:0] RA_CTL = 4'd9;
  localparam logic [3:0] RA_BLK = 4'd10;

endpackage

// File: rtl/vtm_sync.sv
module vtm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise[i] = s2_q & ~s3_q;
    assign fall[i] = ~s2_q & s3_q;
  end

endmodule

// File: rtl/vtm_pulse.sv
module vtm_pulse #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rise,
  input  logic          fall,
  output logic [CW-1:0] hi_w,
  output logic [CW-1:0] lo_w,
  output logic          done
);

  typedef enum logic [2:0] {PT_IDLE, PT_WAIT, PT_HIGH, PT_LOW, PT_DONE} pt_t;

  localparam logic [CW-1:0] ONE = CW'(1);

  pt_t           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, hi_q, hi_d, lo_q, lo_d;
  logic          cnt_en;

  assign cnt_en = (st_q == PT_HIGH) || (st_q == PT_LOW);

  always_comb begin
    st_d  = st_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    cnt_d = cnt_q;
    if (cnt_en && !(&cnt_q)) cnt_d = cnt_q + ONE;
    if (arm) begin
      st_d  = rise ? PT_HIGH : PT_WAIT;
      cnt_d = ONE;
    end else begin
      unique case (st_q)
        PT_WAIT: if (rise) begin
          st_d  = PT_HIGH;
          cnt_d = ONE;
        end
        PT_HIGH: if (fall) begin
          hi_d  = cnt_q;
          cnt_d = ONE;
          st_d  = PT_LOW;
        end
        PT_LOW: if (rise) begin
          lo_d = cnt_q;
          st_d = PT_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PT_IDLE;
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  assign hi_w = hi_q;
  assign lo_w = lo_q;
  assign done = (st_q == PT_DONE);

endmodule

// File: rtl/vtm_ctrl.sv
module vtm_ctrl
  import vtm_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             blk_we,
  input  logic [BLK_W-1:0] blk_wdata,
  input  logic             vs_rise,
  input  logic             hs_rise,
  input  logic             capt_done,
  output phase_t           ph_q,
  output phase_t           ph_d,
  output logic [1:0]       nfr,
  output logic             mode,
  output logic [BLK_W-1:0] blk,
  output logic             trig
);

  localparam int TRIG_W = BLK_W + 2;
  localparam logic [TRIG_W-1:0] ONE_T = TRIG_W'(1);

  phase_t            ph_r;
  logic [1:0]        frm_q, frm_d, nfr_q, nfr_d;
  logic              mode_q, mode_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [TRIG_W-1:0] lcnt_q, lcnt_d, tgt, lcnt_inc;
  logic              idle, frame_last;

  assign idle       = (ph_r == PH_IDLE);
  assign tgt        = (blk_q == '0) ? ONE_T : {blk_q, 2'b00};
  assign lcnt_inc   = lcnt_q + ONE_T;
  assign frame_last = (frm_q == nfr_q);
  assign trig       = (ph_r == PH_WAIT_TRIG) && hs_rise && (lcnt_inc >= tgt);

  always_comb begin
    ph_d   = ph_r;
    frm_d  = frm_q;
    lcnt_d = lcnt_q;
    nfr_d  = nfr_q;
    mode_d = mode_q;
    blk_d  = blk_q;
    if (idle && blk_we) blk_d = blk_wdata;
    unique case (ph_r)
      PH_IDLE: if (ctl_we) begin
        nfr_d  = ctl_wdata[CB_NFR_HI:CB_NFR_LO];
        mode_d = ctl_wdata[CB_MODE];
        if (ctl_wdata[CB_START] && ctl_wdata[CB_MODE]) ph_d = PH_WAIT_VS;
      end
      PH_WAIT_VS: if (vs_rise) begin
        ph_d  = PH_H1;
        frm_d = 2'd0;
      end
      PH_H1, PH_H2, PH_V1, PH_V2: if (vs_rise) begin
        if (frame_last) begin
          frm_d = 2'd0;
          unique case (ph_r)
            PH_H1:   ph_d = PH_H2;
            PH_H2:   ph_d = PH_V1;
            PH_V1:   ph_d = PH_V2;
            default: ph_d = PH_V3;
          endcase
        end else begin
          frm_d = frm_q + 2'd1;
        end
      end
      PH_V3: if (vs_rise) begin
        ph_d   = PH_WAIT_TRIG;
        lcnt_d = '0;
      end
      PH_WAIT_TRIG: if (hs_rise) begin
        lcnt_d = lcnt_inc;
        if (trig) ph_d = PH_CAPT;
      end
      PH_CAPT: if (capt_done) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_r   <= PH_IDLE;
      frm_q  <= '0;
      lcnt_q <= '0;
      nfr_q  <= '0;
      mode_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      ph_r   <= ph_d;
      frm_q  <= frm_d;
      lcnt_q <= lcnt_d;
      nfr_q  <= nfr_d;
      mode_q <= mode_d;
      blk_q  <= blk_d;
    end
  end

  assign ph_q = ph_r;
  assign nfr  = nfr_q;
  assign mode = mode_q;
  assign blk  = blk_q;

endmodule

// File: rtl/vtm_meas.sv
module vtm_meas
  import vtm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        ph_q,
  input  phase_t        ph_d,
  input  logic          hs_rise,
  input  logic          vs_rise,
  input  logic          av_rise,
  input  logic          av_fall,
  output logic [CW-1:0] h1,
  output logic [CW-1:0] h2,
  output logic [CW-1:0] v1,
  output logic [CW-1:0] v2,
  output logic [CW-1:0] v3
);

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] hcnt_q, hcnt_d, acnt_q, acnt_d, vl_q, vl_d, vact_q, vact_d;
  logic [CW-1:0] h1_q, h1_d, h2_q, h2_d, v1_q, v1_d, v2_q, v2_d, v3_q, v3_d;
  logic          hseen_q, hseen_d, aseen_q, aseen_d, vfirst_q, vfirst_d;
  logic          en_h1, en_h2, en_v1, en_v2;

  assign en_h1 = (ph_d == PH_H1) && (ph_q != PH_H1);
  assign en_h2 = (ph_d == PH_H2) && (ph_q != PH_H2);
  assign en_v1 = (ph_d == PH_V1) && (ph_q != PH_V1);
  assign en_v2 = (ph_d == PH_V2) && (ph_q != PH_V2);

  always_comb begin
    hcnt_d   = (&hcnt_q) ? hcnt_q : hcnt_q + ONE;
    acnt_d   = (&acnt_q) ? acnt_q : acnt_q + ONE;
    vl_d     = vl_q;
    vact_d   = vact_q;
    hseen_d  = hseen_q;
    aseen_d  = aseen_q;
    vfirst_d = vfirst_q;
    h1_d     = h1_q;
    h2_d     = h2_q;
    v1_d     = v1_q;
    v2_d     = v2_q;
    v3_d     = v3_q;

    // sync-to-active delay, per line
    if (en_h1) hseen_d = 1'b0;
    if (hs_rise) begin
      hcnt_d  = ONE;
      hseen_d = 1'b1;
    end
    if (en_h1) h1_d = FULL;
    else if (ph_q == PH_H1 && av_rise && hseen_q && hcnt_q < h1_q) h1_d = hcnt_q;

    // active width, per line
    if (en_h2) aseen_d = 1'b0;
    if (av_rise) begin
      acnt_d  = ONE;
      aseen_d = 1'b1;
    end
    if (en_h2) h2_d = FULL;
    else if (ph_q == PH_H2 && av_fall && aseen_q && acnt_q < h2_q) h2_d = acnt_q;

    // line counter since the vertical edge and active pulses per frame
    if (vs_rise) begin
      vl_d     = '0;
      vact_d   = '0;
      vfirst_d = 1'b0;
    end else begin
      if (hs_rise && !(&vl_q)) vl_d = vl_q + ONE;
      if (av_rise) begin
        vfirst_d = 1'b1;
        if (!(&vact_q)) vact_d = vact_q + ONE;
      end
    end

    if (en_v1) v1_d = FULL;
    else if (ph_q == PH_V1 && av_rise && !vfirst_q && vl_q < v1_q) v1_d = vl_q;

    if (en_v2) v2_d = FULL;
    else if (ph_q == PH_V2 && vs_rise && vact_q < v2_q) v2_d = vact_q;

    if (ph_q == PH_V3 && vs_rise) v3_d = vl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= '0;
      acnt_q   <= '0;
      vl_q     <= '0;
      vact_q   <= '0;
      hseen_q  <= 1'b0;
      aseen_q  <= 1'b0;
      vfirst_q <= 1'b0;
      h1_q     <= '0;
      h2_q     <= '0;
      v1_q     <= '0;
      v2_q     <= '0;
      v3_q     <= '0;
    end else begin
      hcnt_q   <= hcnt_d;
      acnt_q   <= acnt_d;
      vl_q     <= vl_d;
      vact_q   <= vact_d;
      hseen_q  <= hseen_d;
      aseen_q  <= aseen_d;
      vfirst_q <= vfirst_d;
      h1_q     <= h1_d;
      h2_q     <= h2_d;
      v1_q     <= v1_d;
      v2_q     <= v2_d;
      v3_q     <= v3_d;
    end
  end

  assign h1 = h1_q;
  assign h2 = h2_q;
  assign v1 = v1_q;
  assign v2 = v2_q;
  assign v3 = v3_q;

endmodule

// File: rtl/vtm_seq.sv
module vtm_seq
  import vtm_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             fly_in,
  input  logic             av_in,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             blk_we,
  input  logic [BLK_W-1:0] blk_wdata,
  input  logic [3:0]       rd_addr,
  output logic [RES_W-1:0] rd_data,
  output logic             busy
);

  localparam int NSIG  = 4;
  localparam int NPT   = 2;
  localparam int SI_HS = 0;
  localparam int SI_VS = 1;
  localparam int SI_FL = 2;
  localparam int SI_AV = 3;

  logic rst_s1_q, rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n_i  <= rst_s1_q;
    end
  end

  logic [NSIG-1:0] s_rise, s_fall;

  vtm_sync #(.W(NSIG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d_in  ({av_in, fly_in, vs_in, hs_in}),
    .rise  (s_rise),
    .fall  (s_fall)
  );

  phase_t           ph_q, ph_d;
  logic [1:0]       nfr_q;
  logic             mode_q, trig, capt_done;
  logic [BLK_W-1:0] blk_q;

  vtm_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .blk_we    (blk_we),
    .blk_wdata (blk_wdata),
    .vs_rise   (s_rise[SI_VS]),
    .hs_rise   (s_rise[SI_HS]),
    .capt_done (capt_done),
    .ph_q      (ph_q),
    .ph_d      (ph_d),
    .nfr       (nfr_q),
    .mode      (mode_q),
    .blk       (blk_q),
    .trig      (trig)
  );

  logic [RES_W-1:0] h1, h2, v1, v2, v3;

  vtm_meas #(.CW(RES_W)) u_meas (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ph_q    (ph_q),
    .ph_d    (ph_d),
    .hs_rise (s_rise[SI_HS]),
    .vs_rise (s_rise[SI_VS]),
    .av_rise (s_rise[SI_AV]),
    .av_fall (s_fall[SI_AV]),
    .h1      (h1),
    .h2      (h2),
    .v1      (v1),
    .v2      (v2),
    .v3      (v3)
  );

  // trigger-line timers: index 0 = horizontal sync, 1 = flyback
  logic [NPT-1:0]   pt_rise, pt_fall, pt_done;
  logic [RES_W-1:0] pt_hi [NPT];
  logic [RES_W-1:0] pt_lo [NPT];

  assign pt_rise = {s_rise[SI_FL], s_rise[SI_HS]};
  assign pt_fall = {s_fall[SI_FL], s_fall[SI_HS]};

  for (genvar k = 0; k < NPT; k++) begin : g_pt
    vtm_pulse #(.CW(RES_W)) u_pt (
      .clk   (clk),
      .rst_n (rst_n_i),
      .arm   (trig),
      .rise  (pt_rise[k]),
      .fall  (pt_fall[k]),
      .hi_w  (pt_hi[k]),
      .lo_w  (pt_lo[k]),
      .done  (pt_done[k])
    );
  end

  assign capt_done = &pt_done;
  assign busy      = (ph_q != PH_IDLE);

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_H1:   rd_data = h1;
      RA_H2:   rd_data = h2;
      RA_H3:   rd_data = pt_lo[0];
      RA_H4:   rd_data = pt_hi[0];
      RA_H5:   rd_data = pt_lo[1];
      RA_H6:   rd_data = pt_hi[1];
      RA_V1:   rd_data = v1;
      RA_V2:   rd_data = v2;
      RA_V3:   rd_data = v3;
      RA_CTL:  rd_data = RES_W'({busy, nfr_q, 4'b0000, mode_q});
      RA_BLK:  rd_data = RES_W'(blk_q);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/vtm_seq_chk.sv
module vtm_seq_chk
  import vtm_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BLK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input phase_t           ph_q,
  input logic [1:0]       nfr_q,
  input logic [BLK_W-1:0] blk_q,
  input logic             capt_done,
  input logic [RES_W-1:0] h1,
  input logic [RES_W-1:0] h2,
  input logic [RES_W-1:0] v1,
  input logic [RES_W-1:0] v2
);

  // R2: a start with timing mode arms the sequence
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_we && ctl_wdata[CB_START] && ctl_wdata[CB_MODE]) |=> busy);

  // R2: a start with mode 0 does not arm
  a_r2_mode0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_we && !ctl_wdata[CB_MODE]) |=> !busy);

  // R3: configuration holds while running
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(nfr_q) && $stable(blk_q)));

  // R4: H1 never grows inside its phase
  a_r4_h1_min: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_H1 && $past(ph_q) == PH_H1) |-> (h1 <= $past(h1)));

  // R5
  a_r5_h2_min: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_H2 && $past(ph_q) == PH_H2) |-> (h2 <= $past(h2)));

  // R6
  a_r6_v1_min: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_V1 && $past(ph_q) == PH_V1) |-> (v1 <= $past(v1)));

  // R7
  a_r7_v2_min: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_V2 && $past(ph_q) == PH_V2) |-> (v2 <= $past(v2)));

  // R11: minimum preset on phase entry
  a_r11_h1_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_H1 && $past(ph_q) == PH_WAIT_VS) |-> (h1 == '1));

  // R9: the run ends once both trigger-line timers finish
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CAPT && capt_done) |=> !busy);

endmodule

bind vtm_seq vtm_seq_chk #(.RES_W(RES_W), .BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .busy      (busy),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ph_q      (ph_q),
  .nfr_q     (nfr_q),
  .blk_q     (blk_q),
  .capt_done (capt_done),
  .h1        (h1),
  .h2        (h2),
  .v1        (v1),
  .v2        (v2)
);

// File: tb/vtm_seq_test.sv
module vtm_seq_test;

  localparam int P    = 40;   // ticks per line
  localparam int L    = 24;   // lines per frame
  localparam int HALF = 20;   // vertical edge offset inside line 0
  localparam int FO   = 26;   // flyback start within a line

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs = 1'b0, vs = 1'b0, fly = 1'b0, av = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic        blk_we = 1'b0;
  logic [7:0]  blk_wdata = 8'h00;
  logic [3:0]  rd_addr = 4'd0;
  logic [11:0] rd_data;
  logic        busy;

  always #5 clk = ~clk;

  vtm_seq uut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs), .vs_in(vs), .fly_in(fly), .av_in(av),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .blk_we(blk_we), .blk_wdata(blk_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int hsw = 4, fw = 6;
  bit av_en = 1, stall_on = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ao(input int i);  return 5 + ((i * 7 + 3) % 5); endfunction
  function automatic int aw(input int i);  return 10 + ((i * 3 + 1) % 6); endfunction
  function automatic int va0(input int i); return 2 + ((i * 5) % 3); endfunction
  function automatic int van(input int i); return 8 + ((i * 2 + 1) % 5); endfunction

  task automatic gen_frame(input int fi);
    for (int ln = 0; ln < L; ln++) begin
      for (int x = 0; x < P; x++) begin
        int g = ln * P + x;
        @(negedge clk);
        hs  = (x < hsw);
        vs  = (g >= HALF) && (g < HALF + 2 * P);
        fly = (x >= FO) && (x < FO + fw);
        av  = av_en && (ln >= va0(fi)) && (ln < va0(fi) + van(fi)) &&
              (x >= ao(fi)) && (x < ao(fi) + aw(fi));
        if (stall_on && fi == 5 && ln == 4 && x == 0) repeat (4200) @(negedge clk);
      end
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_blk(input logic [7:0] d);
    @(negedge clk); blk_we = 1'b1; blk_wdata = d;
    @(negedge clk); blk_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [11:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic run(input int n, input int sbn);
    logic [11:0] v;
    int e1, e2, ev1, ev2, t;
    wr_blk(8'(sbn));
    wr_ctl({1'b1, 2'(n), 4'b0000, 1'b1});
    rd(4'd9, v); check("R2 start sets busy", v[7], 1);
    wr_ctl({1'b0, 2'(~n), 4'b0000, 1'b1});
    wr_blk(8'(sbn + 7));
    rd(4'd9, v); check("R3 ctl held while busy", v, {4'b0, 1'b1, 2'(n), 4'b0000, 1'b1});
    rd(4'd10, v); check("R3 blk held while busy", v, sbn);
    for (int f = 0; f < 4 * n + 6; f++) gen_frame(f);
    rd(4'd9, v); check("R9 busy cleared", v[7], 0);
    e1 = 4095; e2 = 4095; ev1 = 4095; ev2 = 4095;
    for (int f = 0; f <= n; f++) begin
      if (av_en && ao(f) < e1) e1 = ao(f);
      if (av_en && aw(f + n + 1) < e2) e2 = aw(f + n + 1);
      if (av_en && va0(f + 2 * n + 2) < ev1) ev1 = va0(f + 2 * n + 2);
      if (av_en) begin
        if (van(f + 3 * n + 3) < ev2) ev2 = van(f + 3 * n + 3);
      end else ev2 = 0;
    end
    t = (sbn == 0) ? 1 : 4 * sbn;
    rd(4'd0, v); check("R4 H1 min", v, e1);
    rd(4'd1, v); check("R5 H2 min", v, e2);
    rd(4'd6, v); check("R6 V1 min", v, ev1);
    rd(4'd7, v); check("R7 V2 min", v, ev2);
    rd(4'd8, v); check("R8 V3 lines", v, L);
    rd(4'd2, v); check("R9 H3 sync low", v, P - hsw);
    rd(4'd3, v); check("R9 H4 sync high", v, stall_on ? 4095 : hsw);
    rd(4'd4, v); check("R9 H5 fly low", v, P - fw);
    rd(4'd5, v); check("R9 H6 fly high", v, fw);
    if (t + 1 >= L) check("R9 trigger line fits", t, 0);
  endtask

  initial begin
    logic [11:0] v, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), v); check("R1 reset value", v, 0);
    end
    check("R1 busy after reset", busy, 0);

    for (int r = 0; r < 4; r++) begin
      hsw = 3 + r; fw = 5 + r;
      run(r, r + 1);
    end
    hsw = 6; fw = 9;
    run(0, 5);
    hsw = 2; fw = 4;
    run(1, 0);

    // R2: start with mode 0 is refused
    rd(4'd0, keep);
    wr_ctl(8'b1100_0000);
    rd(4'd9, v); check("R2 mode0 readback", v, 12'h040);
    gen_frame(0); gen_frame(1);
    check("R2 mode0 not busy", busy, 0);
    rd(4'd0, v); check("R2 mode0 results kept", v, keep);

    rd(4'd15, v); check("R12 unmapped reads 0", v, 0);
    rd(4'd11, v); check("R12 unmapped reads 0", v, 0);

    // R10 / R11 / R7: no active video, stretched sync on the trigger line
    av_en = 0; stall_on = 1; hsw = 4; fw = 6;
    run(0, 1);
    check("R10 R11 saturation run done", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule